// File: doc/BRIEF.md
# Oversampled serial receiver with two-word holding buffer

This block turns an asynchronous serial line into parallel words. An external strobe marks each sixteenth of a bit period. The block finds the falling edge of a start bit and confirms it at mid-bit. It takes each data bit, least significant first, as a majority of three samples near the bit centre. It then samples the stop bit. Frames carry eight data bits, or nine when the ninth-bit mode is on.

Each finished word goes, with its ninth bit and a framing flag, into a two-entry holding buffer. The host drains the buffer one word at a time through a single read port. The head entry is always visible on the output pins, and a read strobe retires it. A data-available flag stays high while anything is buffered. In nine-bit mode an address filter can discard every frame whose ninth bit is clear. A word that finishes while both entries are full sets a sticky overrun flag. While that flag is set, all later words are dropped. Dropping the receive enable clears it.

Top module: `serial_rx_buffered`

## Requirements
- R1: After reset, `avail`, `overrun` and `rd_ferr` are 0.
- R2: In eight-bit mode a frame made of one low start bit, data bits 0 to 7 (LSB first) and a stop bit is buffered, and `rd_data` shows the byte when it reaches the head.
- R3: With `nine_bit` = 1, the bit sent after data bit 7 is the ninth bit and appears on `rd_bit8` together with its byte. In eight-bit mode `rd_bit8` reads 0.
- R4: `avail` is 1 whenever at least one unread word is buffered, and it falls only after the last one has been read.
- R5: The buffer holds two words, and successive reads return them in arrival order.
- R6: A word that completes while two words are held, with no read in that cycle, sets `overrun` and is discarded.
- R7: While `overrun` is 1 no word enters the buffer. `overrun` returns to 0 only when `cont_en` is 0, after which reception resumes normally.
- R8: Frames are received only while both `port_en` and `cont_en` are 1. A frame sent while either is 0 leaves the buffer unchanged.
- R9: A stop bit sampled as 0 gives the word `rd_ferr` = 1. A good stop bit gives 0. The flag travels with its own word.
- R10: With `nine_bit` = 1 and `addr_det` = 1, only frames whose ninth bit is 1 are buffered.
- R11: A low pulse on `rx` that is high again by the mid-bit sample of the start bit is ignored, and the next proper frame is received correctly.
- R12: A one-sample disturbance near the centre of a data bit does not change the received bit (two-of-three majority).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Oversampling strobe, OVS per bit period |
| rx | input | 1 | Serial line, idle high |
| port_en | input | 1 | Serial port enable |
| cont_en | input | 1 | Continuous receive enable; 0 clears overrun |
| nine_bit | input | 1 | 1 selects nine-bit frames |
| addr_det | input | 1 | Address filter in nine-bit mode |
| rd | input | 1 | Read strobe, retires the head word |
| rd_data | output | DATA_W | Head word data |
| rd_bit8 | output | 1 | Head word ninth bit |
| rd_ferr | output | 1 | Head word framing error |
| avail | output | 1 | Unread data present |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The bench uses the defaults DATA_W = 8, OVS = 16 and DEPTH = 2, with a strobe every second clock, so a full frame lasts about 320 clocks. With a depth of two, the overrun condition needs only a third word, and the flag can be seen both setting and blocking a fourth word within a short run. An oversampling factor of sixteen places the start confirmation and the three vote samples at fixed clock offsets. This lets the bench inject short line pulses that land on the start check or on a single vote sample.

// File: rtl/serial_rx_buffered.sv
module serial_rx_buffered #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rx,
  input  logic              port_en,
  input  logic              cont_en,
  input  logic              nine_bit,
  input  logic              addr_det,
  input  logic              rd,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_bit8,
  output logic              rd_ferr,
  output logic              avail,
  output logic              overrun
);
  localparam int CW  = $clog2(OVS);
  localparam int BW  = $clog2(DATA_W + 1);
  localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int PW  = $clog2(DEPTH + 1);
  localparam int EW  = DATA_W + 2;
  localparam int MID = OVS / 2;
  localparam logic [CW-1:0] C_V0   = CW'(MID - 2);
  localparam logic [CW-1:0] C_V1   = CW'(MID - 1);
  localparam logic [CW-1:0] C_MID  = CW'(MID);
  localparam logic [CW-1:0] C_LAST = CW'(OVS - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_STOP, S_WAITHI} st_t;

  st_t             state;
  logic            rx_meta, rx_s, v0, v1;
  logic [CW-1:0]   cnt;
  logic [BW-1:0]   bitn;
  logic [DATA_W:0] shreg;
  logic [EW-1:0]   mem [DEPTH];
  logic [AW-1:0]   wp, rp;
  logic [PW-1:0]   count;

  wire            act      = port_en & cont_en;
  wire            vote     = (v0 & v1) | (v0 & rx_s) | (v1 & rx_s);
  wire [BW-1:0]   last_bit = nine_bit ? BW'(DATA_W) : BW'(DATA_W - 1);
  wire            done     = act & tick & (state == S_STOP) & (cnt == C_MID);
  wire            keep     = done & ~(addr_det & nine_bit & ~shreg[DATA_W]);
  wire            pop      = rd & (count != '0);
  wire            room     = (count < PW'(DEPTH)) | pop;
  wire            push     = keep & ~overrun & room;
  wire [EW-1:0]   head     = mem[rp];

  assign avail   = (count != '0);
  assign rd_data = head[DATA_W-1:0];
  assign rd_bit8 = head[DATA_W];
  assign rd_ferr = avail & head[DATA_W+1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_meta <= 1'b1;
      rx_s    <= 1'b1;
    end else begin
      rx_meta <= rx;
      rx_s    <= rx_meta;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
      bitn  <= '0;
      shreg <= '0;
      v0    <= 1'b1;
      v1    <= 1'b1;
    end else if (!act) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else if (tick) begin
      if (state == S_IDLE) begin
        if (!rx_s) begin
          state <= S_START;
          cnt   <= '0;
          shreg <= '0;
        end
      end else begin
        cnt <= (cnt == C_LAST) ? '0 : cnt + CW'(1);
        if (cnt == C_V0) v0 <= rx_s;
        if (cnt == C_V1) v1 <= rx_s;
        case (state)
          S_START: begin
            if (cnt == C_V1 && rx_s) state <= S_IDLE;
            else if (cnt == C_LAST) begin
              state <= S_DATA;
              bitn  <= '0;
            end
          end
          S_DATA: begin
            if (cnt == C_MID) shreg[bitn] <= vote;
            if (cnt == C_LAST) begin
              if (bitn == last_bit) state <= S_STOP;
              else bitn <= bitn + BW'(1);
            end
          end
          S_STOP:   if (cnt == C_MID) state <= vote ? S_IDLE : S_WAITHI;
          S_WAITHI: if (rx_s) state <= S_IDLE;
          default:  state <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= {~vote, shreg};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp      <= '0;
      rp      <= '0;
      count   <= '0;
      overrun <= 1'b0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      case ({push, pop})
        2'b10:   count <= count + PW'(1);
        2'b01:   count <= count - PW'(1);
        default: count <= count;
      endcase
      if (!cont_en) overrun <= 1'b0;
      else if (keep & ~room) overrun <= 1'b1;
    end
  end

  // R5: occupancy never exceeds the buffer depth
  a_r5_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= PW'(DEPTH));

  // R4: reading the last word with nothing arriving empties the buffer
  a_r4_last_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && count == PW'(1) && !push) |=> !avail);

  // R7: overrun is gone the cycle after the receive enable drops
  a_r7_overrun_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !cont_en |=> !overrun);

  // R7: while overrun holds, occupancy cannot grow
  a_r7_overrun_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> count <= $past(count));

  // R8: with reception disabled nothing is added
  a_r8_disabled_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    !(port_en && cont_en) |=> count <= $past(count));
endmodule

// File: tb/test_serial_rx_buffered.sv
`timescale 1ns/1ps
module test_serial_rx_buffered;
  localparam int DIV    = 2;
  localparam int BITCLK = 16 * DIV;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, rx = 1'b1;
  logic port_en = 1'b1, cont_en = 1'b1, nine_bit = 1'b0, addr_det = 1'b0, rd = 1'b0;
  logic [7:0] rd_data;
  logic rd_bit8, rd_ferr, avail, overrun;

  int checks = 0, fails = 0, mcnt = 0, tcnt = 0;
  bit movr = 1'b0, finished = 1'b0;
  logic [9:0] exp_q[$];

  always #2 clk = ~clk;

  always @(negedge clk) begin
    tcnt <= (tcnt == DIV - 1) ? 0 : tcnt + 1;
    tick <= (tcnt == DIV - 1);
  end

  serial_rx_buffered i_serial_rx_buffered (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx(rx), .port_en(port_en),
    .cont_en(cont_en), .nine_bit(nine_bit), .addr_det(addr_det), .rd(rd),
    .rd_data(rd_data), .rd_bit8(rd_bit8), .rd_ferr(rd_ferr),
    .avail(avail), .overrun(overrun));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bit_out(input logic v, input bit g);
    for (int i = 0; i < BITCLK; i++) begin
      @(negedge clk);
      rx = (g && i >= 14 && i < 16) ? ~v : v;
    end
  endtask

  // driver: sends a frame and pushes what the buffer should receive
  task automatic send(input logic [8:0] w, input bit stop_v, input bit glitch, input bit enabled);
    bit_out(1'b0, 1'b0);
    for (int b = 0; b < (nine_bit ? 9 : 8); b++) bit_out(w[b], glitch);
    bit_out(stop_v, 1'b0);
    @(negedge clk);
    rx = 1'b1;
    repeat (8) @(negedge clk);
    if (enabled && !(nine_bit && addr_det && !w[8]) && !movr) begin
      if (mcnt < 2) begin
        exp_q.push_back({~stop_v, nine_bit ? w[8] : 1'b0, w[7:0]});
        mcnt++;
      end else movr = 1'b1;
    end
  endtask

  // monitor: compares the head word with the queue, then retires it
  task automatic rd_check(input string req);
    logic [9:0] e;
    @(negedge clk);
    if (exp_q.size() == 0) chk(1'b0, req, avail, 0);
    else begin
      e = exp_q.pop_front();
      chk(avail && {rd_ferr, rd_bit8, rd_data} == e, req, {rd_ferr, rd_bit8, rd_data}, e);
      mcnt--;
    end
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(avail == 0, "R1", avail, 0);
    chk(overrun == 0, "R1", overrun, 0);
    chk(rd_ferr == 0, "R1", rd_ferr, 0);

    send(9'h0A5, 1, 0, 1);
    chk(avail == 1, "R4", avail, 1);
    rd_check("R2");
    chk(avail == 0, "R4", avail, 0);

    nine_bit = 1;
    send(9'h13C, 1, 0, 1);
    send(9'h055, 1, 0, 1);
    rd_check("R3");
    chk(avail == 1, "R4", avail, 1);
    rd_check("R5");
    chk(avail == 0, "R4", avail, 0);
    nine_bit = 0;

    send(9'h03C, 0, 0, 1);
    rd_check("R9");
    send(9'h081, 1, 0, 1);
    rd_check("R9");

    send(9'h011, 1, 0, 1);
    send(9'h022, 1, 0, 1);
    send(9'h033, 1, 0, 1);
    chk(overrun == 1, "R6", overrun, 1);
    send(9'h044, 1, 0, 1);
    rd_check("R6");
    rd_check("R5");
    chk(avail == 0, "R7", avail, 0);
    chk(overrun == 1, "R7", overrun, 1);
    cont_en = 0;
    repeat (2) @(negedge clk);
    chk(overrun == 0, "R7", overrun, 0);
    movr = 0;
    cont_en = 1;
    send(9'h066, 1, 0, 1);
    rd_check("R7");

    port_en = 0;
    send(9'h077, 1, 0, 0);
    chk(avail == 0, "R8", avail, 0);
    port_en = 1;
    cont_en = 0;
    send(9'h078, 1, 0, 0);
    chk(avail == 0, "R8", avail, 0);
    cont_en = 1;
    send(9'h079, 1, 0, 1);
    rd_check("R8");

    nine_bit = 1;
    addr_det = 1;
    send(9'h0AA, 1, 0, 1);
    send(9'h1BB, 1, 0, 1);
    rd_check("R10");
    chk(avail == 0, "R10", avail, 0);
    nine_bit = 0;
    addr_det = 0;

    @(negedge clk);
    rx = 0;
    repeat (12) @(negedge clk);
    rx = 1;
    repeat (600) @(negedge clk);
    chk(avail == 0, "R11", avail, 0);
    send(9'h05A, 1, 0, 1);
    rd_check("R11");

    send(9'h0F0, 1, 1, 1);
    rd_check("R12");
    send(9'h0C3, 1, 1, 1);
    rd_check("R12");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule